// File: doc/BRIEF.md
# Single-Channel Address-Stepping Copy Engine

The engine moves a block of data from one address range to another over a memory port that uses a request/response handshake. Software gives it a start address for each side, a 24-bit cycle count and a set of control fields, then pulses `go`. The engine latches all of these and runs cycles until the count reaches zero. Each cycle is one beat, or four beats in burst mode. Each beat is a read at the source address followed by a write of the returned data to the destination address. After every beat, each address moves by its own signed step.

Each side can also be paced by a hardware request line chosen from up to 15 lines. Before a cycle starts, the engine waits until every selected request line is high. When the cycle ends, it answers each selected line with a one-clock grant. The engine reports its progress on a live down-counting cycle register, so software can read the remaining work at any time. Completion and bus errors are reported through sticky flags that the next accepted `go` clears.

Both request and response channels use valid/ready. A request, with its address, write flag, data, size and bus-select bit, stays valid and unchanged until `req_ready` is high on a clock edge. The engine has at most one request outstanding. It raises `rsp_ready` only while it waits for the answer to that request, and it takes `rsp_valid` only on an edge where `rsp_ready` is high.

Top module: `dma_chan_engine`

## Requirements
- R1: The 3-bit step code of each side moves that side's address after every beat by this amount: 000 and 100 give 0; 001, 010 and 011 give +1, +2 and +4; 101, 110 and 111 give -1, -2 and -4.
- R2: With `cfg_burst` high, every step is four times as large and a cycle holds four read/write beats. With `cfg_burst` low, a cycle holds one beat. Each write carries the data returned by the read just before it.
- R3: `req_size` on every request equals the latched width field: 00 for a 4-byte word, 01 for a 2-byte half, 10 for a single byte.
- R4: `count_now` shows the latched count and drops by exactly one on the edge that accepts the write response of a cycle's last beat.
- R5: A `go` with a count of zero sets `done_flag` on that edge, leaves `busy` low and issues no request.
- R6: When the count reaches zero, `busy` falls and `done_flag` rises on the same edge. Both `done_flag` and `err_flag` stay set until the next accepted `go` clears them.
- R7: A response with `rsp_err` high, whether to a read or a write, stops the transfer on that edge. `busy` falls, `err_flag` rises, `done_flag` stays low and `count_now` keeps its value.
- R8: When a side's request-line number is nonzero, no read request of a new cycle is issued until that line of `hs_req` is high. Line 0 means no pacing.
- R9: At the end of each cycle, `hs_gnt` pulses for one clock on every nonzero line selected by either side, and on no other line.
- R10: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged on the next clock.
- R11: A `go` that arrives while `busy` is high is ignored. The running transfer continues with its latched settings.
- R12: `req_sys` carries the source select bit on reads and the destination select bit on writes (0 for the peripheral bus, 1 for the system bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse; latches all configuration when the engine is idle |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_count | input | 24 | Number of cycles |
| cfg_src_step | input | 3 | Source step code |
| cfg_dst_step | input | 3 | Destination step code |
| cfg_burst | input | 1 | Burst mode: four beats per cycle and steps times four |
| cfg_width | input | 2 | Data width field |
| cfg_src_sys | input | 1 | Source bus select |
| cfg_dst_sys | input | 1 | Destination bus select |
| cfg_src_line | input | 4 | Source request-line number, 0 = none |
| cfg_dst_line | input | 4 | Destination request-line number, 0 = none |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky error flag |
| count_now | output | 24 | Remaining cycles |
| hs_req | input | 16 | Hardware request lines (bit 0 unused) |
| hs_gnt | output | 16 | Hardware grant pulses |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Request address |
| req_wdata | output | 32 | Write data |
| req_size | output | 2 | Transfer size, same code as `cfg_width` |
| req_sys | output | 1 | Bus select for this request |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Engine waiting for a response |
| rsp_rdata | input | 32 | Read data |
| rsp_err | input | 1 | Response reports a bus error |

## Verification
Several things can happen on one edge. The response to a cycle's last write steps both addresses, decrements the count, fires the grant pulse and, when the count was one, also drops `busy` and raises `done_flag`. The bench lets the behavioural model predict all of these for the same edge and compares every output on every clock. An error response to a write in mid-transfer is also provoked, to show that it prevents the count step, the grant and the completion that a good response on that edge would have caused. A `go` is also placed inside a running transfer, under stalls from both `req_ready` and response latency, to show that it is ignored.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int STEP_W    = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_RDREQ,
    S_RDRSP,
    S_WRREQ,
    S_WRRSP
  } seq_state_t;

  typedef struct packed {
    logic [2:0] src_code;
    logic [2:0] dst_code;
    logic       burst;
    logic [1:0] width;
    logic       src_sys;
    logic       dst_sys;
  } chan_cfg_t;

  // magnitude of one address step; the sign comes from code bit 2
  function automatic logic [STEP_W-1:0] step_size(input logic [1:0] sel,
                                                  input logic       burst);
    logic [STEP_W-1:0] m;
    case (sel)
      2'd1:    m = STEP_W'(1);
      2'd2:    m = STEP_W'(2);
      2'd3:    m = STEP_W'(4);
      default: m = '0;
    endcase
    return burst ? STEP_W'(m * BURST_LEN) : m;
  endfunction

endpackage

// File: rtl/dma_step_unit.sv
module dma_step_unit
  import dma_eng_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          advance,
  input  logic [2:0]    code,
  input  logic          burst,
  output logic [AW-1:0] addr
);

  logic [STEP_W-1:0] mag;
  logic [AW-1:0]     addr_q;

  assign mag  = step_size(code[1:0], burst);
  assign addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
    end else if (advance) begin
      if (code[2]) addr_q <= addr_q - AW'(mag);
      else         addr_q <= addr_q + AW'(mag);
    end
  end

endmodule

// File: rtl/dma_hs_gate.sv
module dma_hs_gate #(
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LW-1:0]    src_line,
  input  logic [LW-1:0]    dst_line,
  input  logic [LINES-1:0] hs_req,
  input  logic             cycle_end,
  output logic             hs_ok,
  output logic [LINES-1:0] hs_gnt
);

  logic [LW-1:0]    src_q, dst_q;
  logic [LINES-1:0] gnt_q;
  logic             src_ok, dst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      src_q <= src_line;
      dst_q <= dst_line;
    end
  end

  assign src_ok = (src_q == '0) || hs_req[src_q];
  assign dst_ok = (dst_q == '0) || hs_req[dst_q];
  assign hs_ok  = src_ok && dst_ok;

  for (genvar i = 0; i < LINES; i++) begin : g_gnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q[i] <= 1'b0;
      else        gnt_q[i] <= cycle_end && (i != 0) &&
                              ((src_q == LW'(i)) || (dst_q == LW'(i)));
    end
  end

  assign hs_gnt = gnt_q;

  // R9: a grant lasts a single clock
  p_gnt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |=> (gnt_q == '0));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  chan_cfg_t     cfg_in,
  input  logic [CW-1:0] cfg_count,
  input  logic          hs_ok,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  output chan_cfg_t     cfg_q,
  output logic          load,
  output logic          advance,
  output logic          cycle_end,
  output logic          busy,
  output logic          done_flag,
  output logic          err_flag,
  output logic [CW-1:0] count_now,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [1:0]    req_size,
  output logic          req_sys,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_rdata,
  input  logic          rsp_err
);

  seq_state_t      state;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] last_beat;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   data_q;
  logic            done_q, err_q;
  logic            wr_ok;

  assign last_beat = cfg_q.burst ? BEAT_W'(BURST_LEN - 1) : '0;
  assign load      = go && (state == S_IDLE);
  assign wr_ok     = (state == S_WRRSP) && rsp_valid && !rsp_err;
  assign advance   = wr_ok;
  assign cycle_end = wr_ok && (beat == last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      beat   <= '0;
      cnt    <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (go) begin
            cfg_q  <= cfg_in;
            cnt    <= cfg_count;
            beat   <= '0;
            err_q  <= 1'b0;
            done_q <= (cfg_count == '0);
            if (cfg_count != '0) state <= S_WAIT;
          end
        end
        S_WAIT:  if (hs_ok) state <= S_RDREQ;
        S_RDREQ: if (req_ready) state <= S_RDRSP;
        S_RDRSP: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_q <= 1'b1;
              state <= S_IDLE;
            end else begin
              data_q <= rsp_rdata;
              state  <= S_WRREQ;
            end
          end
        end
        S_WRREQ: if (req_ready) state <= S_WRRSP;
        S_WRRSP: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_q <= 1'b1;
              state <= S_IDLE;
            end else if (beat == last_beat) begin
              beat <= '0;
              cnt  <= cnt - CW'(1);
              if (cnt == CW'(1)) begin
                done_q <= 1'b1;
                state  <= S_IDLE;
              end else begin
                state <= S_WAIT;
              end
            end else begin
              beat  <= beat + BEAT_W'(1);
              state <= S_RDREQ;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done_flag = done_q;
  assign err_flag  = err_q;
  assign count_now = cnt;
  assign req_valid = (state == S_RDREQ) || (state == S_WRREQ);
  assign req_write = (state == S_WRREQ);
  assign req_addr  = req_write ? dst_addr : src_addr;
  assign req_wdata = data_q;
  assign req_size  = cfg_q.width;
  assign req_sys   = req_write ? cfg_q.dst_sys : cfg_q.src_sys;
  assign rsp_ready = (state == S_RDRSP) || (state == S_WRRSP);

  // R10: a stalled request keeps its fields
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata)));

  // R4: while running the count only holds or drops by one
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) - CW'(1))));

  // R6: completion and activity are exclusive
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R7: an error always ends the transfer
  p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (state == S_IDLE) && !done_q);

  // R8: no cycle starts while pacing is not satisfied
  p_hs_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WAIT) && !hs_ok) |=> (state == S_WAIT));

  // R5: zero count finishes at once
  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (state == S_IDLE) && (cfg_count == '0)) |=> (done_q && !busy));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    cfg_src_addr,
  input  logic [AW-1:0]    cfg_dst_addr,
  input  logic [CW-1:0]    cfg_count,
  input  logic [2:0]       cfg_src_step,
  input  logic [2:0]       cfg_dst_step,
  input  logic             cfg_burst,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_src_sys,
  input  logic             cfg_dst_sys,
  input  logic [LW-1:0]    cfg_src_line,
  input  logic [LW-1:0]    cfg_dst_line,
  output logic             busy,
  output logic             done_flag,
  output logic             err_flag,
  output logic [CW-1:0]    count_now,
  input  logic [LINES-1:0] hs_req,
  output logic [LINES-1:0] hs_gnt,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [DW-1:0]    req_wdata,
  output logic [1:0]       req_size,
  output logic             req_sys,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [DW-1:0]    rsp_rdata,
  input  logic             rsp_err
);

  localparam int SIDES = 2;

  chan_cfg_t cfg_in, cfg_q;
  logic      load, advance, cycle_end, hs_ok;
  logic [SIDES-1:0][AW-1:0] side_base, side_addr;
  logic [SIDES-1:0][2:0]    side_code;

  assign cfg_in = '{src_code: cfg_src_step, dst_code: cfg_dst_step,
                    burst: cfg_burst, width: cfg_width,
                    src_sys: cfg_src_sys, dst_sys: cfg_dst_sys};

  assign side_base = {cfg_dst_addr, cfg_src_addr};
  assign side_code = {cfg_q.dst_code, cfg_q.src_code};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_step_unit #(.AW(AW)) i_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (side_base[s]),
      .advance   (advance),
      .code      (side_code[s]),
      .burst     (cfg_q.burst),
      .addr      (side_addr[s])
    );
  end

  dma_hs_gate #(.LINES(LINES), .LW(LW)) i_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .src_line  (cfg_src_line),
    .dst_line  (cfg_dst_line),
    .hs_req    (hs_req),
    .cycle_end (cycle_end),
    .hs_ok     (hs_ok),
    .hs_gnt    (hs_gnt)
  );

  dma_seq #(.AW(AW), .DW(DW), .CW(CW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cfg_in    (cfg_in),
    .cfg_count (cfg_count),
    .hs_ok     (hs_ok),
    .src_addr  (side_addr[0]),
    .dst_addr  (side_addr[1]),
    .cfg_q     (cfg_q),
    .load      (load),
    .advance   (advance),
    .cycle_end (cycle_end),
    .busy      (busy),
    .done_flag (done_flag),
    .err_flag  (err_flag),
    .count_now (count_now),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_size  (req_size),
    .req_sys   (req_sys),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

endmodule

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;

  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        wr;
    logic        last;
    logic        sys;
    logic [31:0] addr;
    logic [31:0] data;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [23:0] cfg_count = '0;
  logic [2:0]  cfg_src_step = '0, cfg_dst_step = '0;
  logic        cfg_burst = 1'b0;
  logic [1:0]  cfg_width = '0;
  logic        cfg_src_sys = 1'b0, cfg_dst_sys = 1'b0;
  logic [3:0]  cfg_src_line = '0, cfg_dst_line = '0;
  logic        busy, done_flag, err_flag;
  logic [23:0] count_now;
  logic [15:0] hs_req = '0;
  logic [15:0] hs_gnt;
  logic        req_valid, req_write, req_sys, rsp_ready;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_rdata = '0;

  dma_chan_engine i_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_count(cfg_count), .cfg_src_step(cfg_src_step),
    .cfg_dst_step(cfg_dst_step), .cfg_burst(cfg_burst),
    .cfg_width(cfg_width), .cfg_src_sys(cfg_src_sys),
    .cfg_dst_sys(cfg_dst_sys), .cfg_src_line(cfg_src_line),
    .cfg_dst_line(cfg_dst_line), .busy(busy), .done_flag(done_flag),
    .err_flag(err_flag), .count_now(count_now), .hs_req(hs_req),
    .hs_gnt(hs_gnt), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_size(req_size), .req_sys(req_sys), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, tcnt = 0;

  // reference model state
  xfer_t       exp_q[$];
  bit          m_busy = 0, m_done = 0, m_err = 0;
  int          m_count = 0;
  logic [1:0]  m_width = '0;
  logic [3:0]  m_sl = '0, m_dl = '0;
  logic [15:0] nxt_gnt = '0;
  bit          pend = 0, p_wr = 0, p_last = 0, p_err = 0;
  int          p_lat = 0;
  logic [31:0] p_data = '0;
  bit          inj_en = 0, inj_wr = 0;
  logic [31:0] inj_addr = '0;

  function automatic logic [31:0] mem_data(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  function automatic int step_of(input logic [2:0] code, input bit burst);
    int m;
    m = (code[1:0] == 2'd0) ? 0 : (1 << (code[1:0] - 1));
    if (burst) m = m * 4;
    return code[2] ? -m : m;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_queue();
    logic [31:0] s, d;
    int beats;
    s = cfg_src_addr;
    d = cfg_dst_addr;
    beats = cfg_burst ? 4 : 1;
    for (int c = 0; c < int'(cfg_count); c++) begin
      for (int b = 0; b < beats; b++) begin
        exp_q.push_back('{wr: 1'b0, last: 1'b0, sys: cfg_src_sys, addr: s, data: '0});
        exp_q.push_back('{wr: 1'b1, last: (b == beats - 1), sys: cfg_dst_sys,
                          addr: d, data: mem_data(s)});
        s = s + step_of(cfg_src_step, cfg_burst);
        d = d + step_of(cfg_dst_step, cfg_burst);
      end
    end
  endtask

  // one clock: decide inputs and model the coming edge, then compare
  task automatic tick();
    bit    consume, accept;
    xfer_t e;
    consume   = pend && (p_lat == 0) && rsp_ready;
    rsp_valid = consume;
    rsp_rdata = consume ? p_data : '0;
    rsp_err   = consume && p_err;
    req_ready = (tcnt % 4) != 1;
    accept    = req_valid && req_ready;
    if (go && !m_busy) begin
      m_done = 0; m_err = 0;
      m_count = int'(cfg_count);
      m_width = cfg_width; m_sl = cfg_src_line; m_dl = cfg_dst_line;
      if (cfg_count == 0) m_done = 1;
      else begin m_busy = 1; build_queue(); end
    end
    if (consume) begin
      pend = 0;
      if (p_err) begin
        m_busy = 0; m_err = 1; exp_q.delete();
      end else if (p_wr && p_last) begin
        m_count--;
        if (m_sl != 0) nxt_gnt[m_sl] = 1'b1;
        if (m_dl != 0) nxt_gnt[m_dl] = 1'b1;
        if (m_count == 0) begin m_busy = 0; m_done = 1; end
      end
    end else if (pend && p_lat != 0) begin
      p_lat--;
    end
    if (accept) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 request after end", {31'd0, req_write, req_addr}, 64'd0);
      end else begin
        e = exp_q.pop_front();
        chk(req_write == e.wr, "R2 read/write order", 64'(req_write), 64'(e.wr));
        chk(req_addr == e.addr, "R1 R2 address step", 64'(req_addr), 64'(e.addr));
        chk(req_size == m_width, "R3 size", 64'(req_size), 64'(m_width));
        chk(req_sys == e.sys, "R12 bus select", 64'(req_sys), 64'(e.sys));
        if (e.wr) chk(req_wdata == e.data, "R2 write data", 64'(req_wdata), 64'(e.data));
        pend   = 1;
        p_wr   = req_write;
        p_last = e.last;
        p_data = mem_data(req_addr);
        p_err  = inj_en && (req_addr == inj_addr) && (req_write == inj_wr);
        p_lat  = tcnt % 3;
      end
    end
    tcnt++;
    @(negedge clk);
    chk(busy == m_busy, "R6 busy", 64'(busy), 64'(m_busy));
    chk(done_flag == m_done, "R6 done flag", 64'(done_flag), 64'(m_done));
    chk(err_flag == m_err, "R7 error flag", 64'(err_flag), 64'(m_err));
    chk(count_now == 24'(m_count), "R4 count", 64'(count_now), 64'(m_count));
    chk(hs_gnt == nxt_gnt, "R9 grant", 64'(hs_gnt), 64'(nxt_gnt));
    nxt_gnt = '0;
  endtask

  task automatic start(input logic [31:0] sa, input logic [31:0] da,
                       input int cnt, input logic [2:0] ss, input logic [2:0] ds,
                       input bit burst, input logic [1:0] w);
    cfg_src_addr = sa; cfg_dst_addr = da; cfg_count = 24'(cnt);
    cfg_src_step = ss; cfg_dst_step = ds; cfg_burst = burst; cfg_width = w;
    go = 1'b1;
    tick();
    go = 1'b0;
  endtask

  task automatic run_out();
    for (int i = 0; i < 3000 && m_busy; i++) tick();
    repeat (3) tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy && !done_flag && !err_flag, "R6 reset flags",
        {61'd0, busy, done_flag, err_flag}, 64'd0);
    chk(count_now == 0 && hs_gnt == 0 && !req_valid, "R4 reset outputs",
        {23'd0, req_valid, hs_gnt, count_now}, 64'd0);

    // plain copy, word width, +4 / +1 (R1 R3 R12)
    cfg_src_sys = 1'b1; cfg_dst_sys = 1'b0;
    start(32'h0000_1000, 32'h0000_2000, 3, 3'b011, 3'b001, 0, 2'b00);
    // a go while running is ignored (R11)
    repeat (3) tick();
    cfg_count = 24'd9; cfg_src_addr = 32'hDEAD_0000;
    go = 1'b1; tick(); go = 1'b0;
    chk(busy && count_now == 24'(m_count), "R11 go while busy ignored",
        64'(count_now), 64'(m_count));
    run_out();
    repeat (4) tick();
    chk(done_flag == 1'b1, "R6 done stays set", 64'(done_flag), 64'd1);

    // burst, byte width, -16 / +8, swapped selects (R2)
    cfg_src_sys = 1'b0; cfg_dst_sys = 1'b1;
    start(32'h0000_8000, 32'h0004_0000, 2, 3'b111, 3'b010, 1, 2'b10);
    chk(done_flag == 1'b0, "R6 go clears done", 64'(done_flag), 64'd0);
    run_out();

    // code 100 gives no step, 110 gives -2, half width (R1)
    start(32'h0000_0300, 32'h0000_0500, 3, 3'b100, 3'b110, 0, 2'b01);
    run_out();
    // burst with code 101 and 000
    start(32'h0000_0A00, 32'h0000_0C00, 2, 3'b101, 3'b000, 1, 2'b00);
    run_out();

    // zero count (R5)
    start(32'h0000_0100, 32'h0000_0200, 0, 3'b001, 3'b001, 0, 2'b00);
    chk(done_flag && !busy && !req_valid, "R5 zero count immediate",
        {61'd0, done_flag, busy, req_valid}, 64'h4);
    repeat (4) tick();

    // handshake pacing on lines 3 and 9 (R8 R9)
    cfg_src_line = 4'd3; cfg_dst_line = 4'd9; hs_req = '0;
    start(32'h0000_4000, 32'h0000_6000, 2, 3'b001, 3'b011, 0, 2'b00);
    for (int i = 0; i < 15; i++) begin
      tick();
      chk(!req_valid, "R8 no request while line low", 64'(req_valid), 64'd0);
    end
    hs_req[3] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(!req_valid, "R8 one of two lines high", 64'(req_valid), 64'd0);
    end
    hs_req[9] = 1'b1;
    run_out();
    hs_req = '0; cfg_src_line = '0; cfg_dst_line = '0;

    // error on the write of the second cycle (R7)
    inj_en = 1; inj_wr = 1; inj_addr = 32'h0000_7004;
    start(32'h0000_3000, 32'h0000_7000, 4, 3'b011, 3'b011, 0, 2'b00);
    run_out();
    chk(err_flag && !done_flag && count_now == 24'd3, "R7 stop on write error",
        {38'd0, err_flag, done_flag, count_now}, {38'd0, 2'b10, 24'd3});
    // error on a read (R7)
    inj_wr = 0; inj_addr = 32'h0000_5008;
    start(32'h0000_5000, 32'h0000_9000, 5, 3'b011, 3'b011, 0, 2'b00);
    run_out();
    chk(err_flag && count_now == 24'd3, "R7 stop on read error",
        {39'd0, err_flag, count_now}, {39'd1, 24'd3});
    inj_en = 0;
    start(32'h0000_1100, 32'h0000_1200, 1, 3'b001, 3'b001, 0, 2'b00);
    chk(err_flag == 1'b0, "R6 go clears error", 64'(err_flag), 64'd0);
    run_out();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule